// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit settles conditional branches for a small 32-bit processor whose instructions are 16 bits wide. The work is split between two operations. A compare operation only stores its two register operands, A and B, in a pair of operand latches. A later branch operation picks one of ten conditions from its instruction word. The unit tests that condition against the stored pair and returns a taken flag and the address of the next instruction.

The decision is signed or unsigned, chosen by the branch and not by the compare. So one compare can serve branches of either kind. The branch's own address and its 10-bit displacement field give the target. Condition codes that name no condition raise an illegal-instruction flag, and the exception unit then takes over.

The result is registered. It appears for exactly one cycle, on the clock edge after the branch is presented.

Top module: `branch_resolver`

## Requirements
- R1: After reset, res_valid, res_taken and res_illegal are 0 and both operand latches hold zero. A branch issued before any compare therefore sees two equal operands: code 0 is taken and code 2 is not.
- R2: A cycle with cmp_valid high copies cmp_a into the first latch and cmp_b into the second. Without that strobe the latches keep their contents. A compare never causes a result pulse.
- R3: The condition code is br_insn[13:10]. Code 0 is taken when the latches are equal, and code 1 when they differ.
- R4: The signed codes treat both latches as two's complement: 2 is first < second, 3 is first > second, 6 is first >= second and 7 is first <= second.
- R5: The unsigned codes compare the latches as unsigned numbers: 4 is <, 5 is >, 8 is >= and 9 is <=.
- R6: Codes 10 to 15 give res_illegal = 1, res_taken = 0 and res_next_pc equal to the branch's own address.
- R7: br_insn[9:0] is a signed displacement counted in 16-bit units. A taken branch gives res_next_pc = br_pc + 2 + 2 * displacement, modulo 2^32.
- R8: A legal branch that is not taken gives res_next_pc = br_pc + 2, since a branch is 2 bytes long.
- R9: The result appears on the clock edge after the cycle in which br_valid is high. res_valid is high for that one cycle per branch. res_taken and res_illegal are 0 whenever res_valid is 0.
- R10: When a compare and a branch come in the same cycle, the branch is tested on the latch contents from before that compare. The new operands take effect from the next branch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | One-cycle strobe that stores the compare operands |
| cmp_a | input | 32 | First compare operand (register A) |
| cmp_b | input | 32 | Second compare operand (register B) |
| br_valid | input | 1 | One-cycle strobe that starts a branch test |
| br_pc | input | 32 | Byte address of the branch instruction |
| br_insn | input | 14 | Low 14 bits of the branch instruction: condition code at [13:10], displacement at [9:0] |
| res_valid | output | 1 | Result strobe, one cycle after br_valid |
| res_taken | output | 1 | Branch is taken |
| res_illegal | output | 1 | Condition code is undefined |
| res_next_pc | output | 32 | Address of the next instruction, or of the faulting branch |

## Verification
The hardest case to reach from the ports is the overlap of a compare and a branch in one cycle. The branch has to use the old latch contents, while the new pair must still be stored for later branches. The bench first loads a known operand pair, then issues a branch together with a compare whose operands reverse the outcome. It then issues a second branch alone, so the stale and the fresh evaluations can both be seen. The signed/unsigned split is driven with operand pairs at the sign boundary (all-ones against one, and the most negative against the most positive value), where each pair of signed and unsigned codes must disagree.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 10,
  parameter int CODE_W = 4,
  parameter int INSN_W = DISP_W + CODE_W,
  parameter int N_CODES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [INSN_W-1:0] br_insn,
  output logic              res_valid,
  output logic              res_taken,
  output logic              res_illegal,
  output logic [ADDR_W-1:0] res_next_pc
);

  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

  logic [DATA_W-1:0] opa_q, opb_q;
  logic [CODE_W-1:0] code;
  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] seq_pc, jump_pc, disp_bytes;
  logic              eq, lt_s, lt_u, bad_code, cond_true;

  assign code = br_insn[DISP_W +: CODE_W];
  assign disp = br_insn[DISP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (cmp_valid) begin
      opa_q <= cmp_a;
      opb_q <= cmp_b;
    end
  end

  assign eq   = (opa_q == opb_q);
  assign lt_s = ($signed(opa_q) < $signed(opb_q));
  assign lt_u = (opa_q < opb_q);
  assign bad_code = (code >= CODE_W'(N_CODES));

  always_comb begin
    unique case (code)
      4'd0:    cond_true = eq;
      4'd1:    cond_true = !eq;
      4'd2:    cond_true = lt_s;
      4'd3:    cond_true = !lt_s && !eq;
      4'd4:    cond_true = lt_u;
      4'd5:    cond_true = !lt_u && !eq;
      4'd6:    cond_true = !lt_s;
      4'd7:    cond_true = lt_s || eq;
      4'd8:    cond_true = !lt_u;
      4'd9:    cond_true = lt_u || eq;
      default: cond_true = 1'b0;
    endcase
  end

  assign disp_bytes = {{(ADDR_W-DISP_W-1){disp[DISP_W-1]}}, disp, 1'b0};
  assign seq_pc     = br_pc + INSN_BYTES;
  assign jump_pc    = seq_pc + disp_bytes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_illegal <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid   <= br_valid;
      res_taken   <= br_valid && !bad_code && cond_true;
      res_illegal <= br_valid && bad_code;
      if (br_valid)
        res_next_pc <= bad_code ? br_pc : (cond_true ? jump_pc : seq_pc);
    end
  end

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (opa_q == $past(cmp_a)) && (opb_q == $past(cmp_b)));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(opa_q) && $stable(opb_q));

  // R3
  eq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && code == 4'd0) |=> res_taken == ($past(opa_q) == $past(opb_q)));

  // R4
  signed_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && code == 4'd2) |=> res_taken == ($signed($past(opa_q)) < $signed($past(opb_q))));

  // R5
  unsigned_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && code == 4'd8) |=> res_taken == ($past(opa_q) >= $past(opb_q)));

  // R6
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_insn[INSN_W-1 -: CODE_W] > 4'd9) |=>
      res_illegal && !res_taken && (res_next_pc == $past(br_pc)));

  // R8
  fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !res_illegal) |-> res_next_pc == $past(br_pc) + INSN_BYTES);

  // R9
  result_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> res_valid);

  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_taken && !res_illegal);

endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pc = '0;
  logic [13:0] br_insn = '0;
  logic        res_valid, res_taken, res_illegal;
  logic [31:0] res_next_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  branch_resolver uut (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_pc(br_pc), .br_insn(br_insn),
    .res_valid(res_valid), .res_taken(res_taken),
    .res_illegal(res_illegal), .res_next_pc(res_next_pc)
  );

  // vector: a, b, code, disp, pc, expected taken, expected illegal
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  code;
    logic [9:0]  disp;
    logic [31:0] pc;
    logic        taken;
    logic        ill;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'd5,        32'd5,        4'd0,  10'h005, 32'h0000_1000, 1'b1, 1'b0},
    '{32'd5,        32'd6,        4'd0,  10'h005, 32'h0000_1000, 1'b0, 1'b0},
    '{32'd5,        32'd6,        4'd1,  10'h1FF, 32'h0000_2000, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'd1,       4'd2,  10'h3FF, 32'h0000_2000, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'd1,       4'd4,  10'h3FF, 32'h0000_2000, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 32'd1,       4'd3,  10'h010, 32'h0000_3000, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 32'd1,       4'd5,  10'h010, 32'h0000_3000, 1'b1, 1'b0},
    '{32'd7,        32'd7,        4'd6,  10'h200, 32'h0000_4000, 1'b1, 1'b0},
    '{32'd7,        32'd7,        4'd7,  10'h000, 32'h0000_4000, 1'b1, 1'b0},
    '{32'h8000_0000, 32'h7FFF_FFFF, 4'd6, 10'h020, 32'h0000_5000, 1'b0, 1'b0},
    '{32'h8000_0000, 32'h7FFF_FFFF, 4'd8, 10'h020, 32'h0000_5000, 1'b1, 1'b0},
    '{32'h8000_0000, 32'h7FFF_FFFF, 4'd9, 10'h020, 32'h0000_5000, 1'b0, 1'b0},
    '{32'd3,        32'd9,        4'd7,  10'h040, 32'h0000_6000, 1'b1, 1'b0},
    '{32'd9,        32'd3,        4'd9,  10'h040, 32'h0000_6000, 1'b0, 1'b0},
    '{32'd0,        32'd0,        4'd0,  10'h200, 32'h0000_0000, 1'b1, 1'b0},
    '{32'd0,        32'd0,        4'd10, 10'h004, 32'h0000_7000, 1'b0, 1'b1},
    '{32'd0,        32'd0,        4'd12, 10'h004, 32'h0000_7100, 1'b0, 1'b1},
    '{32'd0,        32'd0,        4'd15, 10'h3FF, 32'h0000_7200, 1'b0, 1'b1}
  };

  function automatic logic [31:0] model_pc(input logic [31:0] pc, input logic [9:0] disp,
                                           input logic tk, input logic ill);
    int d;
    d = $signed(disp);
    if (ill) return pc;
    if (tk) return pc + 32'd2 + 32'(d * 2);
    return pc + 32'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_compare(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic do_branch(input logic [3:0] code, input logic [9:0] disp, input logic [31:0] pc);
    @(negedge clk);
    br_valid = 1'b1; br_insn = {code, disp}; br_pc = pc;
    @(posedge clk);
    #1;
  endtask

  task automatic end_branch();
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 res_taken", 32'(res_taken), 32'd0);
    check("R1 res_illegal", 32'(res_illegal), 32'd0);
    rst_n = 1'b1;

    // R1: branch before any compare sees zero operands
    do_branch(4'd0, 10'h008, 32'h100);
    check("R1 eq on zero latches", 32'(res_taken), 32'd1);
    check("R1 eq target", res_next_pc, 32'h100 + 32'd2 + 32'd16);
    do_branch(4'd2, 10'h008, 32'h200);
    end_branch();
    check("R1 lt on zero latches", 32'(res_taken), 32'd0);

    // R9: pulse drops after one cycle
    @(posedge clk); #1;
    check("R9 res_valid single cycle", 32'(res_valid), 32'd0);
    check("R9 taken quiet", 32'(res_taken), 32'd0);

    // R2, R9: compare alone gives no result pulse
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = 32'd1; cmp_b = 32'd2;
    @(posedge clk); #1;
    check("R2 compare no pulse", 32'(res_valid), 32'd0);
    @(negedge clk);
    cmp_valid = 1'b0;

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      do_compare(VECS[i].a, VECS[i].b);
      do_branch(VECS[i].code, VECS[i].disp, VECS[i].pc);
      check($sformatf("R9 valid vec %0d", i), 32'(res_valid), 32'd1);
      check($sformatf("R3/R4/R5 taken vec %0d code %0d", i, VECS[i].code),
            32'(res_taken), 32'(VECS[i].taken));
      check($sformatf("R6 illegal vec %0d", i), 32'(res_illegal), 32'(VECS[i].ill));
      check($sformatf("R7/R8 next pc vec %0d", i), res_next_pc,
            model_pc(VECS[i].pc, VECS[i].disp, VECS[i].taken, VECS[i].ill));
      end_branch();
    end

    // R7: wrap below zero: 0 + 2 - 1024
    do_compare(32'd4, 32'd4);
    do_branch(4'd0, 10'h200, 32'h0);
    end_branch();
    check("R7 wrap target", res_next_pc, 32'hFFFF_FC02);

    // R2: latches hold without strobe (still 4,4)
    do_branch(4'd1, 10'h001, 32'h300);
    end_branch();
    check("R2 hold ne", 32'(res_taken), 32'd0);
    check("R8 ne fallthrough", res_next_pc, 32'h302);

    // R10: same-cycle compare and branch uses old pair (4,4)
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = 32'd1; cmp_b = 32'd9;
    br_valid = 1'b1; br_insn = {4'd0, 10'h002}; br_pc = 32'h400;
    @(posedge clk); #1;
    check("R10 old operands eq", 32'(res_taken), 32'd1);
    check("R10 old operands pc", res_next_pc, 32'h406);
    @(negedge clk);
    cmp_valid = 1'b0;
    br_insn = {4'd4, 10'h002}; br_pc = 32'h500;
    @(posedge clk); #1;
    // R9: back-to-back branches keep res_valid high
    check("R9 back-to-back valid", 32'(res_valid), 32'd1);
    check("R10 new operands ltu", 32'(res_taken), 32'd1);
    check("R7 forward target", res_next_pc, 32'h506);
    end_branch();

    // R6: illegal with true-looking operands never taken
    do_branch(4'd11, 10'h010, 32'h800);
    end_branch();
    check("R6 illegal flag", 32'(res_illegal), 32'd1);
    check("R6 illegal not taken", 32'(res_taken), 32'd0);
    check("R6 illegal pc", res_next_pc, 32'h800);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule